// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This unit takes one vector element and moves it by a signed distance: a non-negative distance moves bits toward the most significant end, and a negative distance moves them toward the least significant end by its magnitude. The element may be 8, 16, 32 or 64 bits wide, and the unit can treat it as signed, as unsigned, or as a signed input that must produce an unsigned result. Two enables refine the operation. Rounding adds the last bit dropped by a right move. Saturation clamps a left move whose exact value does not fit the element width.

A vector datapath places one copy of this unit in each lane. It presents an element together with its control fields and a valid strobe, then collects the element-sized result one cycle later, extended to 64 bits. A sticky flag gathers saturation events across many operations until the surrounding logic clears it.

Top module: `vshift_lane`

## Requirements
- R1: `res_valid` equals `op_valid` delayed by one clock; `res_data` is loaded only when `op_valid` was high and otherwise keeps its value.
- R2: `shamt` is an 8-bit two's-complement number (-128..127): a value of 0 or more shifts left, and a negative value shifts right by its magnitude, so 8'hFF shifts right by one. `elem_size` 0/1/2/3 selects widths 8/16/32/64, and source bits above the width are ignored. `op_mode` 0 is signed, 1 is unsigned, 2 is signed-to-unsigned and 3 behaves as unsigned.
- R3: Without rounding, a right shift is arithmetic in signed mode and logical otherwise. A magnitude of at least the width gives all copies of the sign bit in signed mode and 0 otherwise.
- R4: With rounding, a right shift by n returns floor((x + 2^(n-1)) / 2^n). In signed mode any magnitude of at least the width gives 0.
- R5: In the unsigned modes with rounding, a right shift by exactly the width returns the element's top bit, and a larger magnitude returns 0.
- R6: A left shift smaller than the width, when it does not overflow or when saturation is off, returns the shifted value truncated to the width.
- R7: With saturation on, a left shift smaller than the width whose exact value falls outside the element's range saturates and raises the flag.
- R8: A left shift of at least the width returns 0 when the source element is 0 or saturation is off; otherwise it saturates.
- R9: Signed saturation yields the maximum positive value for a non-negative source and the minimum negative value for a negative one. Unsigned saturation yields all ones across the width.
- R10: In signed-to-unsigned mode with saturation on, a source whose top element bit is set gives 0 and raises the flag. Otherwise the element's bit pattern is processed as an unsigned value.
- R11: In signed mode the result is sign-extended from the element width to 64 bits; in the other modes it is zero-extended.
- R12: `sat_sticky` is set in the cycle after an accepted operation saturates, and it holds until `sat_clear` is high. It is never set while saturation is disabled. When a clear and a saturating operation arrive in the same cycle, the flag ends up set.
- R13: While `rst` is high, `res_valid`, `res_data` and `sat_sticky` are all 0 after the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| src_data | input | 64 | Source element in the low bits |
| shamt | input | 8 | Signed shift distance |
| elem_size | input | 2 | Element width select |
| op_mode | input | 2 | Signed, unsigned or signed-to-unsigned |
| round_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Saturate left overflow and negative sources in mode 2 |
| sat_clear | input | 1 | Clear the sticky flag |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Extended result |
| sat_sticky | output | 1 | Accumulated saturation flag |

## Verification
Every result and every change of the sticky flag appears one clock edge after the operation is sampled. The bench therefore drives each operation on a falling edge and compares `res_data`, `res_valid` and `sat_sticky` on the next falling edge, after exactly one rising edge. Checks that need several cycles, such as holding the flag, clearing it or leaving the result unchanged while idle, advance one whole cycle per step and sample at the same mid-cycle point. Expected values come from wide arithmetic: floor division by powers of two for right shifts, and a range test on the exact product for left shifts.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int unsigned LANE_W  = 64;
    localparam int unsigned SHAMT_W = 8;
    localparam int unsigned SIZE_W  = 2;

    typedef enum logic [SIZE_W-1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        OPM_SIGNED   = 2'd0,
        OPM_UNSIGNED = 2'd1,
        OPM_S2U      = 2'd2,
        OPM_SPARE    = 2'd3
    } opmode_e;

    typedef struct packed {
        logic arith_signed;
        logic neg_clamps;
    } mode_ctl_t;

    typedef struct packed {
        logic              valid;
        logic [LANE_W-1:0] data;
    } lane_out_t;

    function automatic logic [SHAMT_W-1:0] width_of(esize_e s);
        return SHAMT_W'(8) << s;
    endfunction

    function automatic logic [LANE_W-1:0] size_mask(esize_e s);
        return {LANE_W{1'b1}} >> (LANE_W - int'(width_of(s)));
    endfunction

    function automatic mode_ctl_t decode_mode(opmode_e m);
        mode_ctl_t c;
        c.arith_signed = (m == OPM_SIGNED);
        c.neg_clamps   = (m == OPM_S2U);
        return c;
    endfunction

    // truncate to the element and extend to the lane
    function automatic logic [LANE_W-1:0] fit_elem(logic [LANE_W-1:0] v, esize_e s, logic sgn);
        logic [LANE_W-1:0] m;
        logic [LANE_W-1:0] low;
        logic              top;
        m   = size_mask(s);
        low = v & m;
        top = |(low & (m ^ (m >> 1)));
        return (sgn && top) ? (low | ~m) : low;
    endfunction

    function automatic logic [LANE_W-1:0] sat_value(esize_e s, logic sgn, logic neg);
        logic [LANE_W-1:0] m;
        m = size_mask(s);
        if (!sgn)
            return m;
        return neg ? ~(m >> 1) : (m >> 1);
    endfunction

endpackage

// File: rtl/vshift_prep.sv
module vshift_prep #(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 8
) (
    input  logic [DW-1:0]        src,
    input  logic [DW-1:0]        mask,
    input  logic                 arith_signed,
    input  logic                 neg_clamps,
    input  logic                 sat_en,
    output logic signed [DW:0]   x_ext,
    output logic                 neg,
    output logic                 force_zero
);
    logic [DW-1:0] el;
    logic [DW-1:0] top_bit;

    always_comb begin
        el         = src & mask;
        top_bit    = mask ^ (mask >> 1);
        neg        = |(el & top_bit);
        if (arith_signed && neg)
            x_ext = {1'b1, el | ~mask};
        else
            x_ext = {1'b0, el};
        force_zero = neg_clamps && sat_en && neg;
    end
endmodule

// File: rtl/vshift_rpath.sv
module vshift_rpath #(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 8
) (
    input  logic signed [DW:0] x_ext,
    input  logic [AW-1:0]      mag,
    input  logic [AW-1:0]      ew,
    input  logic               is_signed,
    input  logic               rnd,
    output logic [DW-1:0]      res
);
    localparam int unsigned SW = $clog2(DW);

    logic              beyond;
    logic [AW-1:0]     k_full;
    logic [SW-1:0]     k;
    logic signed [DW:0] t;
    logic signed [DW:0] r;

    always_comb begin
        if (is_signed)
            beyond = (mag >= ew);
        else
            beyond = (mag > ew) || ((mag == ew) && !rnd);
        k_full = rnd ? (mag - AW'(1)) : mag;
        k      = SW'(k_full);
        t      = x_ext >>> k;
        if (rnd)
            r = (t >>> 1) + $signed({{DW{1'b0}}, t[0]});
        else
            r = t;
        if (beyond)
            res = (is_signed && !rnd) ? {DW{x_ext[DW]}} : '0;
        else
            res = DW'(r);
    end
endmodule

// File: rtl/vshift_lpath.sv
module vshift_lpath #(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 8
) (
    input  logic signed [DW:0] x_ext,
    input  logic [AW-1:0]      amt,
    input  logic [AW-1:0]      ew,
    input  logic               is_signed,
    output logic [DW-1:0]      val,
    output logic               ovf
);
    localparam int unsigned SW = $clog2(DW);
    localparam int unsigned WW = 2 * DW + 1;

    logic signed [WW-1:0] base;
    logic signed [WW-1:0] wide;
    logic signed [WW-1:0] hs;
    logic [AW-1:0]        probe;
    logic                 beyond;
    logic                 fits;
    logic                 nz;

    always_comb begin
        base   = $signed({{DW{x_ext[DW]}}, x_ext});
        wide   = base <<< SW'(amt);
        probe  = is_signed ? (ew - AW'(1)) : ew;
        hs     = wide >>> probe;
        fits   = is_signed ? ((hs == '0) || (hs == '1)) : (hs == '0);
        beyond = (amt >= ew);
        nz     = |x_ext;
        ovf    = beyond ? nz : !fits;
        val    = beyond ? '0 : DW'(wide);
    end
endmodule

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [63:0]        src_data,
    input  logic [7:0]         shamt,
    input  logic [1:0]         elem_size,
    input  logic [1:0]         op_mode,
    input  logic               round_en,
    input  logic               sat_en,
    input  logic               sat_clear,
    output logic               res_valid,
    output logic [63:0]        res_data,
    output logic               sat_sticky
);
    esize_e               sz;
    mode_ctl_t            ctl;
    logic [LANE_W-1:0]    mask;
    logic [SHAMT_W-1:0]   ew;
    logic [SHAMT_W-1:0]   mag;
    logic                 go_right;
    logic signed [LANE_W:0] x_ext;
    logic                 neg;
    logic                 force_zero;
    logic [LANE_W-1:0]    r_res;
    logic [LANE_W-1:0]    l_val;
    logic                 l_ovf;
    logic [LANE_W-1:0]    nxt_data;
    logic                 nxt_sat;
    lane_out_t            q;
    logic                 flag_q;

    always_comb begin
        sz       = esize_e'(elem_size);
        ctl      = decode_mode(opmode_e'(op_mode));
        mask     = size_mask(sz);
        ew       = width_of(sz);
        go_right = shamt[SHAMT_W-1];
        mag      = (~shamt) + SHAMT_W'(1);
    end

    vshift_prep #(.DW(LANE_W), .AW(SHAMT_W)) u_prep (
        .src          (src_data),
        .mask         (mask),
        .arith_signed (ctl.arith_signed),
        .neg_clamps   (ctl.neg_clamps),
        .sat_en       (sat_en),
        .x_ext        (x_ext),
        .neg          (neg),
        .force_zero   (force_zero)
    );

    vshift_rpath #(.DW(LANE_W), .AW(SHAMT_W)) u_rpath (
        .x_ext     (x_ext),
        .mag       (mag),
        .ew        (ew),
        .is_signed (ctl.arith_signed),
        .rnd       (round_en),
        .res       (r_res)
    );

    vshift_lpath #(.DW(LANE_W), .AW(SHAMT_W)) u_lpath (
        .x_ext     (x_ext),
        .amt       (shamt),
        .ew        (ew),
        .is_signed (ctl.arith_signed),
        .val       (l_val),
        .ovf       (l_ovf)
    );

    always_comb begin
        nxt_sat = 1'b0;
        if (force_zero) begin
            nxt_data = '0;
            nxt_sat  = 1'b1;
        end else if (go_right) begin
            nxt_data = fit_elem(r_res, sz, ctl.arith_signed);
        end else if (sat_en && l_ovf) begin
            nxt_data = fit_elem(sat_value(sz, ctl.arith_signed, neg), sz, ctl.arith_signed);
            nxt_sat  = 1'b1;
        end else begin
            nxt_data = fit_elem(l_val, sz, ctl.arith_signed);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            flag_q <= 1'b0;
        end else begin
            q.valid <= op_valid;
            if (op_valid)
                q.data <= nxt_data;
            flag_q <= (flag_q & ~sat_clear) | (op_valid & nxt_sat);
        end
    end

    assign res_valid  = q.valid;
    assign res_data   = q.data;
    assign sat_sticky = flag_q;
endmodule

// File: rtl/vshift_lane_chk.sv
module vshift_lane_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  elem_size,
    input logic [1:0]  op_mode,
    input logic        sat_en,
    input logic        sat_clear,
    input logic        res_valid,
    input logic [63:0] res_data,
    input logic        sat_sticky
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_data));

    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sat_sticky && !sat_clear |=> sat_sticky);

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        sat_clear && !op_valid |=> !sat_sticky);

    // R12
    no_sat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sat_sticky && !(op_valid && sat_en) |=> !sat_sticky);

    // R11
    zext_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_mode != 2'd0) && (elem_size == 2'd0) |=> (res_data[63:8] == '0));

    // R11
    sext_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_mode == 2'd0) && (elem_size == 2'd1)
        |=> ((res_data[63:15] == '0) || (res_data[63:15] == '1)));

    // R13
    reset_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !sat_sticky && (res_data == '0)));
endmodule

bind vshift_lane vshift_lane_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .elem_size  (elem_size),
    .op_mode    (op_mode),
    .sat_en     (sat_en),
    .sat_clear  (sat_clear),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .sat_sticky (sat_sticky)
);

// File: tb/tb_vshift_lane.sv
module tb_vshift_lane;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic [7:0]  shamt = '0;
    logic [1:0]  elem_size = '0;
    logic [1:0]  op_mode = '0;
    logic        round_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        sat_clear = 1'b0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        sat_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    vshift_lane dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_data(src_data),
        .shamt(shamt), .elem_size(elem_size), .op_mode(op_mode),
        .round_en(round_en), .sat_en(sat_en), .sat_clear(sat_clear),
        .res_valid(res_valid), .res_data(res_data), .sat_sticky(sat_sticky)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected result from exact wide arithmetic
    function automatic void ref_model(input logic [63:0] src, input logic [7:0] amt,
                                      input int esz, input int md, input bit rnd, input bit sat,
                                      output logic [63:0] res, output bit s, output string tag);
        int w; int a; int n; bit sgn; bit neg;
        logic [63:0] mask; logic [63:0] el; logic [63:0] low;
        logic signed [199:0] xv; logic signed [199:0] ex;
        logic signed [199:0] lo; logic signed [199:0] hi; logic signed [199:0] one;
        w = 8 << esz;
        sgn = (md == 0);
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        el = src & mask;
        neg = el[w-1];
        one = 1;
        s = 1'b0;
        a = int'($signed(amt));
        if (md == 2 && sat && neg) begin
            res = '0; s = 1'b1; tag = "R10";
            return;
        end
        xv = {136'd0, el};
        if (sgn && neg) xv = xv - (one <<< w);
        if (a < 0) begin
            n = -a;
            if (rnd) ex = (xv + (one <<< (n - 1))) >>> n;
            else     ex = xv >>> n;
            tag = rnd ? "R4" : "R3";
        end else begin
            ex = xv <<< a;
            if (sgn) begin
                lo = -(one <<< (w - 1));
                hi = (one <<< (w - 1)) - one;
            end else begin
                lo = 0;
                hi = (one <<< w) - one;
            end
            tag = (a >= w) ? "R8" : "R6";
            if ((ex < lo || ex > hi) && sat) begin
                s = 1'b1;
                ex = (sgn && xv < 0) ? lo : hi;
                if (a < w) tag = "R7";
            end
        end
        low = ex[63:0] & mask;
        res = (sgn && low[w-1]) ? (low | ~mask) : low;
    endfunction

    // drive one operation, return after its result is registered
    task automatic apply(input logic [63:0] src, input logic [7:0] amt, input int esz,
                         input int md, input bit rnd, input bit sat, input bit clr);
        @(negedge clk);
        op_valid  = 1'b1;
        src_data  = src;
        shamt     = amt;
        elem_size = 2'(esz);
        op_mode   = 2'(md);
        round_en  = rnd;
        sat_en    = sat;
        sat_clear = clr;
        @(negedge clk);
        op_valid  = 1'b0;
        sat_clear = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] srcs [12];
        logic [63:0] er;
        bit          es;
        string       tg;
        int          w;

        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 valid", {63'd0, res_valid}, 64'd0);
        check("R13 data", res_data, 64'd0);
        check("R13 flag", {63'd0, sat_sticky}, 64'd0);
        rst = 1'b0;

        // R2 8'hFF is a right shift by one, upper source bits ignored
        apply(64'hFFFF_FFFF_FFFF_FF40, 8'hFF, 0, 1, 0, 0, 1);
        check("R2 minus-one shift", res_data, 64'h20);
        check("R1 valid", {63'd0, res_valid}, 64'd1);
        // R1 idle cycle keeps data and drops valid
        @(negedge clk);
        check("R1 idle valid", {63'd0, res_valid}, 64'd0);
        check("R1 idle hold", res_data, 64'h20);

        // R5 unsigned rounding at exactly the width
        apply(64'h80, 8'hF8, 0, 1, 1, 0, 1);
        check("R5 round at width", res_data, 64'd1);
        apply(64'h80, 8'hF7, 0, 1, 1, 0, 1);
        check("R5 round past width", res_data, 64'd0);
        // R4 signed rounding at the width gives zero
        apply(64'h80, 8'hF8, 0, 0, 1, 0, 1);
        check("R4 signed round width", res_data, 64'd0);
        // R3 signed no-round past width gives sign fill, R11 extension
        apply(64'h80, 8'hF8, 0, 0, 0, 0, 1);
        check("R3 sign fill", res_data, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(64'hFF, 8'h00, 0, 0, 0, 0, 1);
        check("R11 sign extend", res_data, 64'hFFFF_FFFF_FFFF_FFFF);
        // R9 signed saturation values
        apply(64'h40, 8'h01, 0, 0, 0, 1, 1);
        check("R9 max", res_data, 64'h7F);
        check("R9 flag", {63'd0, sat_sticky}, 64'd1);
        apply(64'hC0, 8'h02, 0, 0, 0, 1, 1);
        check("R9 min", res_data, 64'hFFFF_FFFF_FFFF_FF80);
        apply(64'h01, 8'h10, 1, 1, 0, 1, 1);
        check("R9 unsigned all ones", res_data, 64'hFFFF);
        // R10 signed-to-unsigned
        apply(64'hFF, 8'h00, 0, 2, 0, 1, 1);
        check("R10 neg clamps", res_data, 64'd0);
        check("R10 flag", {63'd0, sat_sticky}, 64'd1);
        apply(64'hFF, 8'h00, 0, 2, 0, 0, 1);
        check("R10 pattern unsigned", res_data, 64'hFF);
        check("R12 no set without sat", {63'd0, sat_sticky}, 64'd0);

        // R12 sticky behaviour
        apply(64'h40, 8'h01, 0, 0, 0, 1, 1);
        apply(64'h01, 8'h01, 0, 0, 0, 1, 0);
        check("R12 holds", {63'd0, sat_sticky}, 64'd1);
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        check("R12 cleared", {63'd0, sat_sticky}, 64'd0);
        apply(64'h40, 8'h01, 0, 0, 0, 1, 1);
        check("R12 set wins over clear", {63'd0, sat_sticky}, 64'd1);

        // sweep every mode, size, corner amount and enable combination
        for (int md = 0; md < 4; md++) begin
            for (int esz = 0; esz < 4; esz++) begin
                int amts [14];
                w = 8 << esz;
                amts = '{0, 1, -1, 2, w - 1, -(w - 1), w, -w, w + 1, -(w + 1), 127, -128, 3, -5};
                srcs[0] = 64'd0;
                srcs[1] = 64'd1;
                srcs[2] = 64'd2;
                srcs[3] = (w == 64) ? 64'h7FFF_FFFF_FFFF_FFFF : ((64'd1 << (w - 1)) - 64'd1);
                srcs[4] = 64'd1 << (w - 1);
                srcs[5] = '1;
                srcs[6] = 64'h5555_5555_5555_5555;
                srcs[7] = 64'hA5A5_A5A5_A5A5_A5A5;
                for (int i = 8; i < 12; i++) srcs[i] = {$urandom(), $urandom()};
                for (int ai = 0; ai < 14; ai++) begin
                    for (int rs = 0; rs < 4; rs++) begin
                        for (int si = 0; si < 12; si++) begin
                            ref_model(srcs[si], 8'(amts[ai]), esz, md, rs[0], rs[1], er, es, tg);
                            apply(srcs[si], 8'(amts[ai]), esz, md, rs[0], rs[1], 1);
                            check({tg, " data"}, res_data, er);
                            check({tg, " flag R12"}, {63'd0, sat_sticky}, {63'd0, es});
                            check("R1 valid", {63'd0, res_valid}, 64'd1);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule